// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block gathers the request lines of up to 64 devices into one shared raw request vector and routes them to a small group of processors. Each processor owns a 64-bit enable mask. Its pending vector is the bitwise AND of that mask and the raw vector. The block raises a level-sensitive interrupt line for every processor whose pending vector is non-zero.

Device logic drives the raw vector through per-source set and clear pulses. Software reaches the masks, the pending vectors and the raw vector through a simple register port that takes only full 64-bit accesses. The register index is the byte offset divided by 64. Indices 0 to NUM_CPU-1 are the masks. Indices NUM_CPU to 2*NUM_CPU-1 are the read-only pending vectors. Index 2*NUM_CPU is the read-only raw vector.

An interrupt to a processor appears and vanishes only when a bit of its masked state changes. A mask write and a change on a request line are both folded into the pending vector at the same clock edge.

Top module: `irq_route_top`

## Requirements
- R1: After reset every mask, the raw vector, every pending vector, every interrupt output, `rd_valid_o` and `err_o` are zero.
- R2: A 1 on bit n of `src_set_i` sets raw bit n at the next clock edge. A 1 on bit n of `src_clr_i` clears it at that edge. If both are 1 for the same bit in the same cycle, the set wins.
- R3: At every edge, pending vector c becomes mask c ANDed with the raw vector, both taken as their values after that edge.
- R4: `irq_o[c]` is 1 exactly one clock edge after pending vector c becomes non-zero, and 0 one edge after it becomes zero.
- R5: A write with `acc_bytes_i` = 8 to index c (c < NUM_CPU) replaces mask c with `wdata_i` at that clock edge.
- R6: A mask write that clears a bit pending for that processor removes the bit from its pending vector at the same edge. The interrupt line drops one edge later if no other bit is pending.
- R7: The index is `addr_i` shifted right by 6. Bits 5:0 of the offset have no effect on which register is accessed.
- R8: An access with `acc_bytes_i` other than 8 raises `err_o` for one cycle after the edge, leaves all state unchanged and returns no read data.
- R9: A write to a pending index or to the raw index raises `err_o` and changes no mask or vector.
- R10: A legal read returns the register value from before the edge on `rd_data_o`, with `rd_valid_o` high for one cycle after that edge. A read of an index above 2*NUM_CPU raises `err_o` instead, with `rd_valid_o` low.
- R11: When a mask write and a source set for the same bit fall in the same cycle, the pending vector shows the bit at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_set_i | input | NUM_SRC | Per-source raise pulses |
| src_clr_i | input | NUM_SRC | Per-source drop pulses |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset from the block base |
| acc_bytes_i | input | 4 | Access size in bytes; only 8 is legal |
| wdata_i | input | DW | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DW | Read data |
| err_o | output | 1 | Illegal access flag, one cycle |
| irq_o | output | NUM_CPU | Per-processor device interrupt |

## Verification
A mask write and a raw-vector change can land on the same edge. The bench provokes this in two ways. In the first, a mask write enables bit 7 of processor 0 while `src_set_i` raises bit 7 in the same cycle. The bench requires the pending bit at that edge and the interrupt one edge later. In the second, a source set and a source clear hit the same bit together, and the bench expects the set to win in the raw readback.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int OFS_BITS  = 6;
  localparam int ACC_BYTES = 8;

  typedef enum logic [1:0] {
    RK_MASK = 2'd0,
    RK_PEND = 2'd1,
    RK_RAW  = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_raw_vec.sv
module irq_raw_vec #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] raw_nxt_o,
  output logic [NUM_SRC-1:0] raw_o
);
  logic [NUM_SRC-1:0] raw_q, raw_d;

  always_comb begin
    raw_d = (raw_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_nxt_o = raw_d;
  assign raw_o     = raw_q;

  // R2
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));
  // R2
  raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((raw_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int AW      = 12,
  localparam int IDXW   = AW - OFS_BITS,
  localparam int CPUW   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [IDXW-1:0]    idx_i,
  input  logic [3:0]         acc_bytes_i,
  output reg_kind_e          kind_o,
  output logic [CPUW-1:0]    sel_o,
  output logic [NUM_CPU-1:0] mask_we_o,
  output logic               rd_go_o,
  output logic               err_o
);
  localparam logic [IDXW-1:0] PEND_BASE = IDXW'(NUM_CPU);
  localparam logic [IDXW-1:0] RAW_IDX   = IDXW'(2 * NUM_CPU);

  logic            size_ok;
  logic [IDXW-1:0] rel;

  always_comb begin
    size_ok = (acc_bytes_i == 4'(ACC_BYTES));
    rel     = idx_i;
    if (idx_i < PEND_BASE) begin
      kind_o = RK_MASK;
    end else if (idx_i < RAW_IDX) begin
      kind_o = RK_PEND;
      rel    = idx_i - PEND_BASE;
    end else if (idx_i == RAW_IDX) begin
      kind_o = RK_RAW;
    end else begin
      kind_o = RK_NONE;
    end
    sel_o   = rel[CPUW-1:0];
    err_o   = req_i & (!size_ok || (kind_o == RK_NONE) ||
                       (we_i && (kind_o != RK_MASK)));
    rd_go_o = req_i & !we_i & !err_o;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
    assign mask_we_o[c] = req_i & we_i & !err_o & (kind_o == RK_MASK) &
                          (sel_o == CPUW'(c));
  end

  // R5
  mask_we_onehot_chk: assert final ($onehot0(mask_we_o));
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] raw_nxt_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d, pend_q, pend_d;
  logic               irq_q, irq_d;

  always_comb begin
    mask_d = wr_en_i ? wdata_i : mask_q;
    pend_d = mask_d & raw_nxt_i;
    irq_d  = |pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i) mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_q));
  // R6
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((pend_q & ~$past(wdata_i)) == '0));
  // R3
  pend_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) == '0));
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  parameter int DW      = 64,
  parameter int AW      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic [NUM_SRC-1:0] src_clr_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [3:0]         acc_bytes_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               rd_valid_o,
  output logic [DW-1:0]      rd_data_o,
  output logic               err_o,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam int IDXW = AW - OFS_BITS;
  localparam int CPUW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic                rst_ns;
  logic [NUM_SRC-1:0]  raw_nxt, raw_q;
  logic [NUM_SRC-1:0]  mask_a [NUM_CPU];
  logic [NUM_SRC-1:0]  pend_a [NUM_CPU];
  reg_kind_e           kind;
  logic [CPUW-1:0]     sel;
  logic [NUM_CPU-1:0]  mask_we;
  logic                rd_go, dec_err;
  logic [DW-1:0]       rdata_d, rdata_q;
  logic                rvalid_q, err_q;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  irq_raw_vec #(.NUM_SRC(NUM_SRC)) u_raw (
    .clk(clk), .rst_n(rst_ns), .set_i(src_set_i), .clr_i(src_clr_i),
    .raw_nxt_o(raw_nxt), .raw_o(raw_q)
  );

  irq_reg_decode #(.NUM_CPU(NUM_CPU), .AW(AW)) u_dec (
    .req_i(req_i), .we_i(we_i), .idx_i(addr_i[AW-1:OFS_BITS]),
    .acc_bytes_i(acc_bytes_i), .kind_o(kind), .sel_o(sel),
    .mask_we_o(mask_we), .rd_go_o(rd_go), .err_o(dec_err)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk(clk), .rst_n(rst_ns), .wr_en_i(mask_we[c]),
      .wdata_i(wdata_i[NUM_SRC-1:0]), .raw_nxt_i(raw_nxt),
      .mask_o(mask_a[c]), .pend_o(pend_a[c]), .irq_o(irq_o[c])
    );

    // R3
    pend_and_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (pend_a[c] == (mask_a[c] & raw_q)));
    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (|pend_a[c]) |=> irq_o[c]);
  end

  always_comb begin
    rdata_d = '0;
    unique case (kind)
      RK_MASK: rdata_d = DW'(mask_a[sel]);
      RK_PEND: rdata_d = DW'(pend_a[sel]);
      RK_RAW:  rdata_d = DW'(raw_q);
      default: rdata_d = '0;
    endcase
    if (!rd_go) rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
      rdata_q  <= rdata_d;
      err_q    <= dec_err;
    end
  end

  assign rd_valid_o = rvalid_q;
  assign rd_data_o  = rdata_q;
  assign err_o      = err_q;

  // R8
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_i && acc_bytes_i != 4'(ACC_BYTES)) |=> (err_o && !rd_valid_o));
  // R10
  rd_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !(rd_valid_o && err_o));
endmodule

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;
  localparam int NC = 4;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_set, src_clr;
  logic          req, we;
  logic [11:0]   addr;
  logic [3:0]    acc;
  logic [63:0]   wdata;
  logic          rvalid, err;
  logic [63:0]   rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_route_top u0 (
    .clk(clk), .rst_n(rst_n), .src_set_i(src_set), .src_clr_i(src_clr),
    .req_i(req), .we_i(we), .addr_i(addr), .acc_bytes_i(acc),
    .wdata_i(wdata), .rd_valid_o(rvalid), .rd_data_o(rdata),
    .err_o(err), .irq_o(irq)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [3:0] sz);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; acc = sz;
    tick();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] sz,
                    output logic [63:0] d, output logic v, output logic e);
    req = 1'b1; we = 1'b0; addr = a; acc = sz;
    tick();
    req = 1'b0;
    d = rdata; v = rvalid; e = err;
  endtask

  task automatic rd_chk(input string rq, input logic [11:0] a, input logic [63:0] exp);
    logic [63:0] d; logic v, e;
    rd(a, 4'd8, d, v, e);
    chk(rq, {63'd0, v}, 64'd1);
    chk(rq, d, exp);
  endtask

  function automatic logic [11:0] ofs(input int idx);
    return 12'(idx * 64);
  endfunction

  task automatic pulse_src(input logic [63:0] s, input logic [63:0] c);
    src_set = s; src_clr = c;
    tick();
    src_set = '0; src_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {60'd0, irq}, 64'd0);
    chk("R1 err", {63'd0, err}, 64'd0);
    chk("R1 rvalid", {63'd0, rvalid}, 64'd0);
    for (int i = 0; i <= 2 * NC; i++) rd_chk("R1 reg", ofs(i), 64'd0);
  endtask

  task automatic t_raw();
    pulse_src((64'd1 << 63) | 64'd8, '0);
    rd_chk("R2 raw set", ofs(8), (64'd1 << 63) | 64'd8);
    pulse_src('0, 64'd8);
    rd_chk("R2 raw clr", ofs(8), 64'd1 << 63);
    pulse_src(64'd32, 64'd32);
    rd_chk("R2 set wins", ofs(8), (64'd1 << 63) | 64'd32);
    pulse_src('0, 64'd32);
  endtask

  task automatic t_mask_post();
    wr(ofs(0), 64'd1 << 63, 4'd8);
    chk("R5 no err", {63'd0, err}, 64'd0);
    rd_chk("R5 mask0", ofs(0), 64'd1 << 63);
    chk("R4 irq0 up", {63'd0, irq[0]}, 64'd1);
    chk("R4 irq1 idle", {63'd0, irq[1]}, 64'd0);
    rd_chk("R3 pend0", ofs(4), 64'd1 << 63);
  endtask

  task automatic t_mask_drop();
    wr(ofs(0), 64'h0, 4'd8);
    rd_chk("R6 pend0 gone", ofs(4), 64'd0);
    chk("R6 irq0 down", {63'd0, irq[0]}, 64'd0);
    pulse_src('0, 64'd1 << 63);
  endtask

  task automatic t_fanout();
    wr(ofs(1), 64'd1 << 10, 4'd8);
    wr(ofs(2), (64'd1 << 10) | 64'd1, 4'd8);
    pulse_src(64'd1 << 10, '0);
    chk("R4 no irq same edge", {60'd0, irq}, 64'd0);
    tick();
    chk("R4 fanout irq", {60'd0, irq}, 64'b0110);
    rd_chk("R3 pend2", ofs(6), 64'd1 << 10);
    pulse_src('0, 64'd1 << 10);
    rd_chk("R3 pend1 cleared", ofs(5), 64'd0);
    chk("R4 fanout drop", {60'd0, irq}, 64'd0);
  endtask

  task automatic t_offset();
    wr(ofs(3) | 12'h028, 64'hA5A5_0000_0000_5A5A, 4'd8);
    rd_chk("R7 mask3", ofs(3) | 12'h03F, 64'hA5A5_0000_0000_5A5A);
    rd_chk("R7 mask2 untouched", ofs(2), (64'd1 << 10) | 64'd1);
  endtask

  task automatic t_bad_size();
    logic [63:0] d; logic v, e;
    wr(ofs(2), 64'hFFFF, 4'd4);
    chk("R8 write err", {63'd0, err}, 64'd1);
    rd_chk("R8 mask2 kept", ofs(2), (64'd1 << 10) | 64'd1);
    rd(ofs(2), 4'd2, d, v, e);
    chk("R8 read err", {63'd0, e}, 64'd1);
    chk("R8 read no valid", {63'd0, v}, 64'd0);
  endtask

  task automatic t_ro_write();
    wr(ofs(5), 64'hFF, 4'd8);
    chk("R9 pend write err", {63'd0, err}, 64'd1);
    wr(ofs(8), 64'hFF, 4'd8);
    chk("R9 raw write err", {63'd0, err}, 64'd1);
    rd_chk("R9 raw kept", ofs(8), 64'd0);
    rd_chk("R9 mask1 kept", ofs(1), 64'd1 << 10);
    tick();
    chk("R9 irq idle", {60'd0, irq}, 64'd0);
  endtask

  task automatic t_unmapped();
    logic [63:0] d; logic v, e;
    rd(ofs(20), 4'd8, d, v, e);
    chk("R10 unmapped err", {63'd0, e}, 64'd1);
    chk("R10 unmapped no valid", {63'd0, v}, 64'd0);
    tick();
    chk("R10 err one cycle", {63'd0, err}, 64'd0);
  endtask

  task automatic t_same_cycle();
    req = 1'b1; we = 1'b1; addr = ofs(0); wdata = 64'd1 << 7; acc = 4'd8;
    src_set = 64'd1 << 7;
    tick();
    req = 1'b0; we = 1'b0; src_set = '0;
    chk("R11 irq not yet", {63'd0, irq[0]}, 64'd0);
    rd_chk("R11 pend0 both", ofs(4), 64'd1 << 7);
    chk("R11 irq0 up", {63'd0, irq[0]}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; src_set = '0; src_clr = '0; req = 1'b0; we = 1'b0;
    addr = '0; acc = 4'd8; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raw();
    t_mask_post();
    t_mask_drop();
    t_fanout();
    t_offset();
    t_bad_size();
    t_ro_write();
    t_unmapped();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule